// File: doc/BRIEF.md
# SPI Interrupt Flag and Trigger Logic

This block turns the status of a serial peripheral interface into two interrupt request lines: one for receive and one for transmit. It works in one of two schemes, and a mode input chooses between them. In the legacy scheme, single-word events set sticky flags. A receive overrun sets an overrun flag. A received word or an empty transmit buffer sets a general flag. Both flags report on the receive line only, and the transmit line stays low. In the queued scheme, the receive line follows a comparison between the receive fill count and a trigger level. The transmit line follows a comparison between the transmit fill count and its own trigger level. A receive queue overflow sets a separate sticky flag.

The two trigger levels are held in small registers inside the block. Each register has its own write strobe. The surrounding peripheral supplies the fill counts, the enables and single-cycle event pulses. It clears flags through write-one clear inputs. There is no data stream here, so every pin is a plain level or pulse with no handshake.

Top module: `spi_irq_gen`

## Requirements
- R1: After reset all three flags read 0, the receive trigger level reads all ones (7 when CNT_W=3), the transmit trigger level reads 0, and the transmit line is low.
- R2: With queued mode off, a pulse on ev_rx_ovrn sets flag_ovrn at the next clock edge, and irq_rx then equals ovrn_ie while flag_spi is clear.
- R3: With queued mode off, a pulse on either ev_rx_word or ev_tx_empty sets flag_spi at the next clock edge, and irq_rx then equals spi_ie while flag_ovrn is clear.
- R4: Every flag stays set until its clear input is 1 at a clock edge. A clear in the same cycle as a new event for that flag leaves the flag set.
- R5: ev_rx_ovrn, ev_rx_word and ev_tx_empty do not change any flag while queued mode is on. ev_rxff_ovf sets flag_rxff_ovf only while queued mode is on.
- R6: With queued mode on, irq_rx is 1 exactly when rxff_ie is 1 and rx_fill >= rx_lvl, whatever the legacy flags hold.
- R7: irq_tx is 1 exactly when queued mode is on, txff_ie is 1 and tx_fill <= tx_lvl. It is 0 whenever queued mode is off.
- R8: A write strobe loads the matching trigger level from its data input at the clock edge. The new value is visible on the level output from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 selects the queued scheme, 0 the legacy scheme |
| rx_fill | input | CNT_W | Receive queue fill count |
| tx_fill | input | CNT_W | Transmit queue fill count |
| rx_lvl_we | input | 1 | Load strobe for the receive trigger level |
| rx_lvl_wdata | input | CNT_W | New receive trigger level |
| tx_lvl_we | input | 1 | Load strobe for the transmit trigger level |
| tx_lvl_wdata | input | CNT_W | New transmit trigger level |
| ovrn_ie | input | 1 | Legacy overrun interrupt enable |
| spi_ie | input | 1 | Legacy general interrupt enable |
| rxff_ie | input | 1 | Queued receive interrupt enable |
| txff_ie | input | 1 | Queued transmit interrupt enable |
| ev_rx_ovrn | input | 1 | Receive overrun pulse |
| ev_rx_word | input | 1 | Word received pulse |
| ev_tx_empty | input | 1 | Transmit buffer empty pulse |
| ev_rxff_ovf | input | 1 | Receive queue overflow pulse |
| clr_ovrn | input | 1 | Write-one clear of flag_ovrn |
| clr_spi | input | 1 | Write-one clear of flag_spi |
| clr_rxff_ovf | input | 1 | Write-one clear of flag_rxff_ovf |
| flag_ovrn | output | 1 | Sticky overrun flag |
| flag_spi | output | 1 | Sticky general flag |
| flag_rxff_ovf | output | 1 | Sticky receive queue overflow flag |
| rx_lvl | output | CNT_W | Current receive trigger level |
| tx_lvl | output | CNT_W | Current transmit trigger level |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |

## Verification
The bench builds the block with CNT_W=3, so fill counts and trigger levels each take only eight values. At that size it can sweep every pairing of level and fill for both comparators, with each enable value. This covers both equality boundaries and the all-ones level after reset. The legacy scheme is swept over every pair of enables and each event kind. Checks on mode gating and on a clear arriving in the same cycle as an event are added to that sweep.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_OVRN  = 0;
  localparam int FLG_SPI   = 1;
  localparam int FLG_RXFF  = 2;

  typedef enum logic {
    SCHEME_LEGACY = 1'b0,
    SCHEME_QUEUED = 1'b1
  } scheme_e;
endpackage

// File: rtl/spi_irq_flag.sv
module spi_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R4
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q); // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> $stable(q)); // R4
endmodule

// File: rtl/spi_irq_lvl_reg.sv
module spi_irq_lvl_reg #(
  parameter int          CNT_W   = 5,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] d,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else if (we) q <= d;
  end

  AST_LVL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d))); // R8
endmodule

// File: rtl/spi_irq_level_cmp.sv
module spi_irq_level_cmp #(
  parameter int CNT_W   = 5,
  parameter bit AT_LEAST = 1'b1
) (
  input  logic             en,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] level,
  output logic             hit
);
  logic cmp;
  generate
    if (AT_LEAST) begin : g_ge
      assign cmp = (fill >= level);
    end else begin : g_le
      assign cmp = (fill <= level);
    end
  endgenerate
  assign hit = en & cmp;
endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen
  import spi_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic [CNT_W-1:0] tx_fill,
  input  logic             rx_lvl_we,
  input  logic [CNT_W-1:0] rx_lvl_wdata,
  input  logic             tx_lvl_we,
  input  logic [CNT_W-1:0] tx_lvl_wdata,
  input  logic             ovrn_ie,
  input  logic             spi_ie,
  input  logic             rxff_ie,
  input  logic             txff_ie,
  input  logic             ev_rx_ovrn,
  input  logic             ev_rx_word,
  input  logic             ev_tx_empty,
  input  logic             ev_rxff_ovf,
  input  logic             clr_ovrn,
  input  logic             clr_spi,
  input  logic             clr_rxff_ovf,
  output logic             flag_ovrn,
  output logic             flag_spi,
  output logic             flag_rxff_ovf,
  output logic [CNT_W-1:0] rx_lvl,
  output logic [CNT_W-1:0] tx_lvl,
  output logic             irq_rx,
  output logic             irq_tx
);
  localparam logic [CNT_W-1:0] RX_LVL_RST = '1;
  localparam logic [CNT_W-1:0] TX_LVL_RST = '0;

  scheme_e scheme;
  assign scheme = scheme_e'(fifo_mode);

  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic                 legacy_rx, queued_rx, queued_tx;

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_OVRN] = (scheme == SCHEME_LEGACY) & ev_rx_ovrn;
    flag_set[FLG_SPI]  = (scheme == SCHEME_LEGACY) & (ev_rx_word | ev_tx_empty);
    flag_set[FLG_RXFF] = (scheme == SCHEME_QUEUED) & ev_rxff_ovf;
    flag_clr           = '0;
    flag_clr[FLG_OVRN] = clr_ovrn;
    flag_clr[FLG_SPI]  = clr_spi;
    flag_clr[FLG_RXFF] = clr_rxff_ovf;
  end

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      spi_irq_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (flag_set[i]),
        .clr  (flag_clr[i]),
        .q    (flag_q[i])
      );
    end
  endgenerate

  spi_irq_lvl_reg #(.CNT_W(CNT_W), .RST_VAL(RX_LVL_RST)) u_rx_lvl (
    .clk(clk), .rst_n(rst_n), .we(rx_lvl_we), .d(rx_lvl_wdata), .q(rx_lvl)
  );
  spi_irq_lvl_reg #(.CNT_W(CNT_W), .RST_VAL(TX_LVL_RST)) u_tx_lvl (
    .clk(clk), .rst_n(rst_n), .we(tx_lvl_we), .d(tx_lvl_wdata), .q(tx_lvl)
  );

  spi_irq_level_cmp #(.CNT_W(CNT_W), .AT_LEAST(1'b1)) u_rx_cmp (
    .en(rxff_ie), .fill(rx_fill), .level(rx_lvl), .hit(queued_rx)
  );
  spi_irq_level_cmp #(.CNT_W(CNT_W), .AT_LEAST(1'b0)) u_tx_cmp (
    .en(txff_ie), .fill(tx_fill), .level(tx_lvl), .hit(queued_tx)
  );

  assign legacy_rx = (flag_q[FLG_OVRN] & ovrn_ie) | (flag_q[FLG_SPI] & spi_ie);

  always_comb begin
    if (scheme == SCHEME_QUEUED) begin
      irq_rx = queued_rx;
      irq_tx = queued_tx;
    end else begin
      irq_rx = legacy_rx;
      irq_tx = 1'b0;
    end
  end

  assign flag_ovrn     = flag_q[FLG_OVRN];
  assign flag_spi      = flag_q[FLG_SPI];
  assign flag_rxff_ovf = flag_q[FLG_RXFF];

  AST_LEGACY_RX_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !flag_ovrn && !flag_spi) |-> !irq_rx); // R2
  AST_QUEUED_NO_LEGACY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |=> !$rose(flag_spi)); // R5
  AST_LEGACY_NO_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !$rose(flag_rxff_ovf)); // R5
  AST_TX_QUIET_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !irq_tx); // R7
endmodule

// File: tb/spi_irq_gen_tb_top.sv
`timescale 1ns/1ps
module spi_irq_gen_tb_top;
  localparam int CNT_W = 3;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0;
  logic [CNT_W-1:0] rx_fill = '0, tx_fill = '0, rx_lvl_wdata = '0, tx_lvl_wdata = '0;
  logic rx_lvl_we = 0, tx_lvl_we = 0;
  logic ovrn_ie = 0, spi_ie = 0, rxff_ie = 0, txff_ie = 0;
  logic ev_rx_ovrn = 0, ev_rx_word = 0, ev_tx_empty = 0, ev_rxff_ovf = 0;
  logic clr_ovrn = 0, clr_spi = 0, clr_rxff_ovf = 0;
  logic flag_ovrn, flag_spi, flag_rxff_ovf, irq_rx, irq_tx;
  logic [CNT_W-1:0] rx_lvl, tx_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_irq_gen #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .rx_fill(rx_fill), .tx_fill(tx_fill),
    .rx_lvl_we(rx_lvl_we), .rx_lvl_wdata(rx_lvl_wdata),
    .tx_lvl_we(tx_lvl_we), .tx_lvl_wdata(tx_lvl_wdata),
    .ovrn_ie(ovrn_ie), .spi_ie(spi_ie), .rxff_ie(rxff_ie), .txff_ie(txff_ie),
    .ev_rx_ovrn(ev_rx_ovrn), .ev_rx_word(ev_rx_word), .ev_tx_empty(ev_tx_empty),
    .ev_rxff_ovf(ev_rxff_ovf),
    .clr_ovrn(clr_ovrn), .clr_spi(clr_spi), .clr_rxff_ovf(clr_rxff_ovf),
    .flag_ovrn(flag_ovrn), .flag_spi(flag_spi), .flag_rxff_ovf(flag_rxff_ovf),
    .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_ovrn = 1; clr_spi = 1; clr_rxff_ovf = 1;
    tick();
    clr_ovrn = 0; clr_spi = 0; clr_rxff_ovf = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1", "flag_ovrn", flag_ovrn, 0);
    chk("R1", "flag_spi", flag_spi, 0);
    chk("R1", "flag_rxff_ovf", flag_rxff_ovf, 0);
    chk("R1", "rx_lvl", rx_lvl, MAXV);
    chk("R1", "tx_lvl", tx_lvl, 0);
    chk("R1", "irq_tx", irq_tx, 0);

    // R2 / R3 legacy sweep over enables and event kinds
    for (int oe = 0; oe < 2; oe++)
      for (int se = 0; se < 2; se++)
        for (int ev = 0; ev < 3; ev++) begin
          ovrn_ie = oe[0]; spi_ie = se[0];
          ev_rx_ovrn = (ev == 0); ev_rx_word = (ev == 1); ev_tx_empty = (ev == 2);
          txff_ie = 1; tx_fill = '0;
          tick();
          ev_rx_ovrn = 0; ev_rx_word = 0; ev_tx_empty = 0;
          #1;
          if (ev == 0) begin
            chk("R2", "flag_ovrn", flag_ovrn, 1);
            chk("R2", "irq_rx", irq_rx, oe);
          end else begin
            chk("R3", "flag_spi", flag_spi, 1);
            chk("R3", "irq_rx", irq_rx, se);
          end
          chk("R7", "irq_tx legacy", irq_tx, 0);
          // R4 sticky over idle cycles
          tick(); tick();
          chk("R4", "held", (ev == 0) ? flag_ovrn : flag_spi, 1);
          clear_all();
          chk("R4", "cleared ovrn", flag_ovrn, 0);
          chk("R4", "cleared spi", flag_spi, 0);
        end

    // R4 clear in the same cycle as an event
    ev_rx_word = 1; clr_spi = 1;
    tick();
    ev_rx_word = 0; clr_spi = 0;
    chk("R4", "set beats clear spi", flag_spi, 1);
    ev_rx_ovrn = 1; clr_ovrn = 1;
    tick();
    ev_rx_ovrn = 0; clr_ovrn = 0;
    chk("R4", "set beats clear ovrn", flag_ovrn, 1);
    clear_all();

    // R5 overflow pulse ignored in legacy mode
    ev_rxff_ovf = 1;
    tick();
    ev_rxff_ovf = 0;
    chk("R5", "ovf in legacy", flag_rxff_ovf, 0);

    // R5 legacy events ignored in queued mode
    fifo_mode = 1;
    ev_rx_ovrn = 1; ev_rx_word = 1; ev_tx_empty = 1;
    tick();
    ev_rx_ovrn = 0; ev_rx_word = 0; ev_tx_empty = 0;
    chk("R5", "ovrn in queued", flag_ovrn, 0);
    chk("R5", "spi in queued", flag_spi, 0);
    ev_rxff_ovf = 1;
    tick();
    ev_rxff_ovf = 0;
    chk("R5", "ovf in queued", flag_rxff_ovf, 1);
    ev_rxff_ovf = 1; clr_rxff_ovf = 1;
    tick();
    ev_rxff_ovf = 0; clr_rxff_ovf = 0;
    chk("R4", "set beats clear ovf", flag_rxff_ovf, 1);
    clear_all();
    chk("R4", "cleared ovf", flag_rxff_ovf, 0);

    // park legacy flags set with enables on, to prove R6 ignores them
    fifo_mode = 0; ovrn_ie = 1; spi_ie = 1;
    ev_rx_ovrn = 1; ev_rx_word = 1;
    tick();
    ev_rx_ovrn = 0; ev_rx_word = 0;
    fifo_mode = 1;

    // R6 / R7 / R8 exhaustive sweep of level against fill
    for (int lv = 0; lv <= MAXV; lv++) begin
      rx_lvl_we = 1; tx_lvl_we = 1;
      rx_lvl_wdata = lv[CNT_W-1:0]; tx_lvl_wdata = lv[CNT_W-1:0];
      tick();
      rx_lvl_we = 0; tx_lvl_we = 0;
      rx_lvl_wdata = '0; tx_lvl_wdata = '0;
      chk("R8", "rx_lvl", rx_lvl, lv);
      chk("R8", "tx_lvl", tx_lvl, lv);
      for (int ie = 0; ie < 2; ie++)
        for (int f = 0; f <= MAXV; f++) begin
          rxff_ie = ie[0]; txff_ie = ie[0];
          rx_fill = f[CNT_W-1:0]; tx_fill = f[CNT_W-1:0];
          #1;
          chk("R6", "irq_rx", irq_rx, (ie == 1 && f >= lv) ? 1 : 0);
          chk("R7", "irq_tx", irq_tx, (ie == 1 && f <= lv) ? 1 : 0);
          tick();
        end
    end

    // R7 queued comparator true but legacy mode forces low
    txff_ie = 1; tx_fill = '0;
    fifo_mode = 0;
    #1;
    chk("R7", "irq_tx forced low", irq_tx, 0);
    chk("R2", "legacy rx back", irq_rx, 1);

    done = 1;
    summary();
  end
endmodule